// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every beat of a read or write burst inside an SDRAM device model or controller datapath. A read or write command loads a starting column, a length code and an ordering bit. From the next cycle on, the block steps through the burst and presents one column per cycle. Alongside each column it drives a beat-valid flag, and on the final beat of a fixed-length burst it also raises a last-beat flag.

Two orderings are supported. Sequential order increments the low address bits and wraps them inside the window aligned to the burst length. Interleaved order XORs the beat count into those same low bits. A full-page length is allowed only with sequential order; it runs over every column, wrapping at the top, until something stops it. Any burst can be cut short on any cycle, either by a terminate input or by a fresh command that replaces it.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, and whenever no burst is running, valid_o and last_o are 0. Directly after reset col_o is 0.
- R2: When start_i is sampled high on a clock edge, valid_o is 1 after that edge and col_o equals the start_col_i value that was sampled.
- R3: With btype_i = 0 (sequential) and a fixed length L, beat k presents the start column with its low log2(L) bits replaced by (start + k) mod L. The upper bits stay unchanged.
- R4: With btype_i = 1 (interleaved) and a fixed length L, beat k presents the start column with its low log2(L) bits XORed with k.
- R5: The length code blen_i selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives a full page. The codes 3'b100 to 3'b110 are treated as length 1.
- R6: last_o is 1 only together with valid_o, and only on beat L-1 of a fixed-length burst. On the cycle after that beat, valid_o is 0 unless a new command was sampled.
- R7: A sequential full-page burst increments the column by one on every beat and wraps from 255 to 0. It keeps running until it is terminated or replaced, and last_o never rises during it.
- R8: Code 3'b111 combined with the interleaved type runs as an interleaved burst of 8 beats.
- R9: When term_i is sampled high without start_i, valid_o is 0 after that edge. term_i has no effect while the block is idle. When start_i and term_i are both high, the new burst starts.
- R10: A new command sampled on any beat of a running burst, at an even or an odd beat, abandons that burst. The new burst begins after the same edge at its own start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Read or write command: load and begin a burst |
| start_col_i | input | COL_W | Starting column for the burst |
| blen_i | input | 3 | Burst length code |
| btype_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| term_i | input | 1 | Burst terminate |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A burst beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench builds the block with its defaults: an 8-bit column and a largest fixed length of 8. With these values a full-page burst that starts at column 250 crosses the 255-to-0 wrap within a few beats. The longest fixed burst is short enough that starts in every low-bit phase, and interrupts at both even and odd beats, fit into a brief run. The same defaults let every length code, including the reserved codes and the interleaved full-page combination, be run against a scoreboard of columns computed from the ordering rules.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam logic [2:0] BLEN_FULL = 3'b111;

  function automatic logic [15:0] win_mask(input logic [4:0] lg);
    logic [16:0] one_sh;
    one_sh = 17'(1) << lg;
    return 16'(one_sh - 17'(1));
  endfunction
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode #(
  parameter int COL_W      = 8,
  parameter int MAX_FIX_LG = 3,
  localparam int LG_W      = $clog2(COL_W + 1)
) (
  input  logic [2:0]      blen_i,
  input  logic            ilv_i,
  output logic [LG_W-1:0] lg_o,
  output logic            full_o
);
  import colgen_pkg::*;

  always_comb begin
    lg_o   = '0;
    full_o = 1'b0;
    if (blen_i == BLEN_FULL) begin
      // interleaved full page is not legal: fall back to the longest fixed length
      if (ilv_i) begin
        lg_o = LG_W'(MAX_FIX_LG);
      end else begin
        lg_o   = LG_W'(COL_W);
        full_o = 1'b1;
      end
    end else if (int'(blen_i) <= MAX_FIX_LG) begin
      lg_o = LG_W'(blen_i);
    end
  end
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic             full_i,
  input  logic [COL_W-1:0] mask_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic             last_o
);
  logic             active_q;
  logic [COL_W-1:0] beat_q;
  logic             at_end;

  assign at_end = !full_i && (beat_q == mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
    end else if (active_q) begin
      if (term_i || at_end) begin
        active_q <= 1'b0;
      end else begin
        beat_q <= beat_q + COL_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign last_o   = active_q && at_end;
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;

  always_comb begin
    if (ilv_i) low = (base_i ^ beat_i) & mask_i;
    else       low = (base_i + beat_i) & mask_i;
    col_o = (base_i & ~mask_i) | low;
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W      = 8,
  parameter int MAX_FIX_LG = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             btype_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  import colgen_pkg::*;

  localparam int LG_W = $clog2(COL_W + 1);

  logic [LG_W-1:0]  lg_d, lg_q;
  logic             full_d, full_q;
  logic             ilv_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] beat;
  logic             active;

  colgen_len_decode #(.COL_W(COL_W), .MAX_FIX_LG(MAX_FIX_LG)) i_dec (
    .blen_i (blen_i),
    .ilv_i  (btype_i),
    .lg_o   (lg_d),
    .full_o (full_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lg_q   <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
    end else if (start_i) begin
      lg_q   <= lg_d;
      full_q <= full_d;
      ilv_q  <= btype_i;
      base_q <= start_col_i;
    end
  end

  assign mask = COL_W'(win_mask(5'(lg_q)));

  colgen_beat_ctr #(.COL_W(COL_W)) i_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .term_i   (term_i),
    .full_i   (full_q),
    .mask_i   (mask),
    .active_o (active),
    .beat_o   (beat),
    .last_o   (last_o)
  );

  colgen_addr_map #(.COL_W(COL_W)) i_map (
    .base_i (base_q),
    .beat_i (beat),
    .mask_i (mask),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );

  assign valid_o = active;
endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             full_i,
  input logic             ilv_i
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  a_r2_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && (col_o == $past(start_col_i)));

  a_r6_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  a_r6_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o);

  a_r7_full_no_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full_i |-> !last_o);

  a_r7_full_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full_i && !ilv_i && !start_i && !term_i |=> valid_o && (col_o == $past(col_o) + ONE));

  a_r9_term_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i && !start_i |=> !valid_o);

  a_r3_fixed_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !start_i && !term_i |=> valid_o);
endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .full_i      (full_q),
  .ilv_i       (ilv_q)
);

// File: tb/test_sdram_burst_colgen.sv
`timescale 1ns/1ps
module test_sdram_burst_colgen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] blen_i = '0;
  logic       btype_i = 1'b0;
  logic       term_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o;
  logic       last_o;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  typedef struct {
    bit         vld;
    logic [7:0] col;
    bit         lst;
    string      req;
  } exp_t;
  exp_t q[$];

  always #2 clk_i = ~clk_i;

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .btype_i(btype_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int blen_of(logic [2:0] code, logic ilv);
    case (code)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return ilv ? 8 : 256;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_col(logic [7:0] s, int k, int len, logic ilv);
    int m, si, lo;
    m  = len - 1;
    si = int'(s);
    lo = ilv ? ((si ^ k) & m) : ((si + k) & m);
    return 8'((si & ~m & 255) | lo);
  endfunction

  task automatic push(bit v, logic [7:0] c, bit l, string r);
    exp_t e;
    e.vld = v; e.col = c; e.lst = l; e.req = r;
    q.push_back(e);
  endtask

  task automatic burst(logic [7:0] s, logic [2:0] code, logic ilv, int cycles,
                       bit term_first, string r);
    int  len;
    bit  full;
    len  = blen_of(code, ilv);
    full = (code == 3'b111) && !ilv;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk_i);
      start_i = (k == 0); start_col_i = s; blen_i = code; btype_i = ilv;
      term_i = (k == 0) && term_first;
      if (full || k < len) push(1, exp_col(s, k, len, ilv), !full && (k == len - 1), r);
      else                 push(0, 8'h00, 0, r);
    end
  endtask

  task automatic idle(int n, bit trm, string r);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      start_i = 0; term_i = trm;
      push(0, 8'h00, 0, r);
    end
  endtask

  // monitor: compare after each edge against the scoreboard
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (valid_o !== e.vld) begin
          bad++;
          $display("FAIL %s valid_o=%0b expected %0b", e.req, valid_o, e.vld);
        end else if (e.vld && (col_o !== e.col || last_o !== e.lst)) begin
          bad++;
          $display("FAIL %s col_o=%02h last_o=%0b expected col=%02h last=%0b",
                   e.req, col_o, last_o, e.col, e.lst);
        end else if (!e.vld && last_o !== 1'b0) begin
          bad++;
          $display("FAIL %s last_o=%0b expected 0 while idle", e.req, last_o);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    total++;
    if (valid_o !== 1'b0 || last_o !== 1'b0 || col_o !== 8'h00) begin
      bad++;
      $display("FAIL R1 valid=%0b last=%0b col=%02h expected 0 0 00", valid_o, last_o, col_o);
    end
    idle(2, 0, "R1");
    // R2 R3 sequential fixed lengths
    burst(8'h35, 3'b010, 0, 5, 0, "R3");
    burst(8'h8D, 3'b011, 0, 9, 0, "R3");
    burst(8'h7F, 3'b001, 0, 3, 0, "R2");
    burst(8'hC6, 3'b000, 0, 2, 0, "R5");
    // R4 interleaved
    burst(8'h4B, 3'b011, 1, 9, 0, "R4");
    burst(8'h1E, 3'b010, 1, 5, 0, "R4");
    burst(8'h93, 3'b001, 1, 3, 0, "R4");
    // R5 reserved code acts as length 1
    burst(8'h5A, 3'b101, 0, 2, 0, "R5");
    burst(8'h5B, 3'b110, 1, 2, 0, "R5");
    // R7 full page wraps and runs until terminated
    burst(8'hFA, 3'b111, 0, 12, 0, "R7");
    idle(1, 1, "R7");
    idle(1, 0, "R7");
    // R8 interleaved plus full-page code runs as 8
    burst(8'h26, 3'b111, 1, 9, 0, "R8");
    // R9 terminate mid-burst, while idle, and together with start
    burst(8'h40, 3'b011, 0, 3, 0, "R9");
    idle(1, 1, "R9");
    idle(2, 1, "R9");
    burst(8'h62, 3'b010, 0, 5, 1, "R9");
    // R10 interrupt at odd and even beats
    burst(8'h10, 3'b011, 0, 2, 0, "R10");
    burst(8'hA5, 3'b011, 1, 3, 0, "R10");
    burst(8'hE1, 3'b010, 0, 5, 0, "R10");
    burst(8'h00, 3'b111, 0, 4, 0, "R10");
    burst(8'h33, 3'b001, 0, 3, 0, "R10");
    idle(3, 0, "R6");
    @(negedge clk_i);
    @(negedge clk_i);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule